// File: doc/BRIEF.md
# First-Spike Winner-Take-All Inhibitor

This block sits at the output of a column of spiking neurons and applies lateral inhibition across them. It watches the neuron spike lines on every tick of the unit clock. The first neuron to fire in a computation wave is the only one whose spike reaches the column output. Every other neuron's output is forced low until the wave ends. When several neurons fire in the same earliest tick, the neuron with the lowest index wins.

The winning spike appears on its output line in the same tick as the input, with no register delay. It is then held as a level rather than a pulse, so the output stays high even after the neuron's input drops. The block also exports the latched winner as a one-hot vector with a valid flag, for use by the learning logic.

A wave ends on a rising edge of the gamma clock. The block turns that edge into a one-cycle clear pulse, and the pulse empties the holding register. A parameter selects how the holding register is cleared: asynchronously by the active-high pulse, or synchronously by its active-low complement.

Top module: `wta_first_spike`

## Requirements
- R1: While `rst` is high and after it is released, `spike_out` and `winner_onehot` are all zero and `winner_valid` is low, until a spike arrives.
- R2: With no winner latched, a spike on neuron i alone drives `spike_out[i]` high in the same clock cycle, and no other output bit is high.
- R3: Once a winner is latched, spikes from other neurons arriving in later cycles of the same wave never raise their outputs; at most one `spike_out` bit is high at any time.
- R4: When several neurons spike in the same earliest cycle, only the lowest-numbered one (bit 0 is neuron 0) wins.
- R5: The winner's `spike_out` bit stays high after its input drops, until the wave is cleared; while a winner is held, `spike_out` equals `winner_onehot`.
- R6: A repeat spike from the latched winner, or any later spike, leaves the outputs unchanged.
- R7: At the clock edge that samples the winning spike, `winner_onehot` takes the winner's one-hot code and `winner_valid` goes high; `winner_onehot` is never more than one-hot.
- R8: A 0-to-1 change of `gamma_clk` seen at clock edge k clears all outputs and `winner_valid` by clock edge k+1; spikes sampled at edge k+1 are dropped.
- R9: In a wave in which no neuron spikes, all outputs stay low and `winner_valid` stays low.
- R10: Holding `gamma_clk` high does not clear again; a new wave can latch a winner while `gamma_clk` remains high.
- R11: Parameter `CLR_STYLE` selects an asynchronous active-high clear (`CLR_ASYNC_HIGH`) or a synchronous active-low clear (`CLR_SYNC_LOW`) of the holding register. Both give the same port behaviour when sampled one clock after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock; spikes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gamma_clk | input | 1 | Gamma clock level, synchronous to `clk`; a rising edge ends the wave |
| spike_in | input | Q | Neuron spike inputs, bit i from neuron i |
| spike_out | output | Q | Inhibited outputs, held as levels until the wave clears |
| winner_onehot | output | Q | Registered one-hot code of the latched winner |
| winner_valid | output | 1 | High while a winner is latched |

## Verification
On every cycle, the assertions check the following:
- `spike_out` and `winner_onehot` are never more than one-hot.
- `spike_out` mirrors the held winner.
- An unlocked cycle with spikes grants the lowest set bit and latches it at the next edge.
- The winner stays stable unless a gamma rising edge has just been seen.

Only the bench scenarios can show the following:
- The reset state.
- Idle waves.
- Staggered and repeated spikes being ignored.
- A spike dropped in the clear cycle.
- Behaviour while `gamma_clk` stays high.
- That the two clear styles agree at the ports.

// File: rtl/wta_pkg.sv
package wta_pkg;

    // How the winner holding register is emptied at the end of a wave.
    typedef enum logic {
        CLR_ASYNC_HIGH = 1'b0,  // asynchronous clear, active-high pulse
        CLR_SYNC_LOW   = 1'b1   // synchronous clear, active-low level
    } clr_style_e;

    // Default column width.
    localparam int unsigned WTA_DEFAULT_Q = 8;

endpackage

// File: rtl/wta_wave_pulse.sv
// Turns a rising edge of the gamma clock level into a registered
// one-cycle clear pulse in the unit clock domain.
module wta_wave_pulse (
    input  logic clk,
    input  logic rst,
    input  logic gamma_clk,
    output logic wave_clr
);
    logic gamma_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gamma_q  <= 1'b0;
            wave_clr <= 1'b0;
        end else begin
            gamma_q  <= gamma_clk;
            wave_clr <= gamma_clk & ~gamma_q;
        end
    end
endmodule

// File: rtl/wta_first_pick.sv
// Fixed-priority picker: the lowest-numbered active request wins.
module wta_first_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // seen[i] is high when any request below index i is active.
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/wta_hold_reg.sv
// Sticky register that turns granted pulses into levels, emptied by the
// wave clear. The clear style is chosen by parameter.
module wta_hold_reg
    import wta_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter clr_style_e  STYLE = CLR_ASYNC_HIGH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    if (STYLE == CLR_ASYNC_HIGH) begin : g_async
        always_ff @(posedge clk or posedge clr) begin
            if (clr)
                q <= '0;
            else if (rst)
                q <= '0;
            else
                q <= q | set;
        end
    end else begin : g_sync
        logic clr_n;

        assign clr_n = ~clr;

        always_ff @(posedge clk) begin
            if (!clr_n || rst)
                q <= '0;
            else
                q <= q | set;
        end
    end
endmodule

// File: rtl/wta_first_spike.sv
// Column-level first-spike winner-take-all inhibitor.
module wta_first_spike
    import wta_pkg::*;
#(
    parameter int unsigned Q         = WTA_DEFAULT_Q,
    parameter clr_style_e  CLR_STYLE = CLR_ASYNC_HIGH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gamma_clk,
    input  logic [Q-1:0] spike_in,
    output logic [Q-1:0] spike_out,
    output logic [Q-1:0] winner_onehot,
    output logic         winner_valid
);
    logic         wave_clr;
    logic [Q-1:0] grant;
    logic [Q-1:0] set_vec;
    logic [Q-1:0] won_q;
    logic         locked;

    wta_wave_pulse u_pulse (
        .clk      (clk),
        .rst      (rst),
        .gamma_clk(gamma_clk),
        .wave_clr (wave_clr)
    );

    wta_first_pick #(.N(Q)) u_pick (
        .req  (spike_in),
        .grant(grant)
    );

    assign locked  = |won_q;
    assign set_vec = locked ? '0 : grant;

    wta_hold_reg #(.W(Q), .STYLE(CLR_STYLE)) u_hold (
        .clk(clk),
        .rst(rst),
        .clr(wave_clr),
        .set(set_vec),
        .q  (won_q)
    );

    // The winning pulse passes straight through in its own cycle; the
    // held bit keeps it high for the rest of the wave.
    assign spike_out     = won_q | (wave_clr ? '0 : set_vec);
    assign winner_onehot = won_q;
    assign winner_valid  = locked;
endmodule

// File: rtl/wta_first_spike_chk.sv
module wta_first_spike_chk #(
    parameter int unsigned Q = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         gamma_clk,
    input logic [Q-1:0] spike_in,
    input logic [Q-1:0] spike_out,
    input logic [Q-1:0] winner_onehot,
    input logic         winner_valid
);
    // Independent gamma edge tracking.
    logic         g_d1;
    logic         rise;
    logic         rise_d;
    logic [Q-1:0] lsb_pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_d1   <= 1'b0;
            rise_d <= 1'b0;
        end else begin
            g_d1   <= gamma_clk;
            rise_d <= rise;
        end
    end

    assign rise     = gamma_clk & ~g_d1;
    assign lsb_pick = spike_in & (~spike_in + 1'b1);

    assert_out_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spike_out));

    assert_winner_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(winner_onehot));

    assert_lowest_grant_R4: assert property (@(posedge clk) disable iff (rst)
        (!winner_valid && spike_in != '0 && !rise_d) |-> (spike_out == lsb_pick));

    assert_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (!winner_valid && spike_in != '0 && !rise && !rise_d)
        |=> (winner_valid && winner_onehot == $past(lsb_pick)));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (winner_valid && !rise && !rise_d) |=> $stable(winner_onehot));

    assert_out_mirrors_R5: assert property (@(posedge clk) disable iff (rst)
        winner_valid |-> (spike_out == winner_onehot));
endmodule

bind wta_first_spike wta_first_spike_chk #(.Q(Q)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .gamma_clk    (gamma_clk),
    .spike_in     (spike_in),
    .spike_out    (spike_out),
    .winner_onehot(winner_onehot),
    .winner_valid (winner_valid)
);

// File: tb/wta_first_spike_test.sv
module wta_first_spike_test;
    localparam int Q = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         gamma_clk;
    logic [Q-1:0] spike_in;
    logic [Q-1:0] out_a, win_a;
    logic [Q-1:0] out_s, win_s;
    logic         val_a, val_s;
    int           total = 0;
    int           bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    wta_first_spike #(.Q(Q), .CLR_STYLE(wta_pkg::CLR_ASYNC_HIGH)) uut (
        .clk(clk), .rst(rst), .gamma_clk(gamma_clk), .spike_in(spike_in),
        .spike_out(out_a), .winner_onehot(win_a), .winner_valid(val_a)
    );

    // Second instance with the other clear style (R11).
    wta_first_spike #(.Q(Q), .CLR_STYLE(wta_pkg::CLR_SYNC_LOW)) uut_sync (
        .clk(clk), .rst(rst), .gamma_clk(gamma_clk), .spike_in(spike_in),
        .spike_out(out_s), .winner_onehot(win_s), .winner_valid(val_s)
    );

    function automatic logic [Q-1:0] lowest(input logic [Q-1:0] v);
        for (int i = 0; i < Q; i++)
            if (v[i]) return Q'(1) << i;
        return '0;
    endfunction

    task automatic chk(input string req, input logic [Q-1:0] got,
                       input logic [Q-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Compare the spike outputs of both instances.
    task automatic chk_out(input string req, input logic [Q-1:0] exp);
        chk(req, out_a, exp);
        chk({req, " R11 sync"}, out_s, exp);
    endtask

    // Compare the winner vector and valid flag of both instances.
    task automatic chk_win(input string req, input logic [Q-1:0] exp);
        chk(req, win_a, exp);
        chk({req, " R11 sync"}, win_s, exp);
        chk({req, " valid"}, Q'(val_a), Q'(exp != '0));
        chk({req, " valid R11 sync"}, Q'(val_s), Q'(exp != '0));
    endtask

    task automatic drive(input logic [Q-1:0] v);
        @(negedge clk);
        spike_in = v;
        #1;
    endtask

    // R8: gamma rising edge, then check the wave is empty.
    task automatic wave_clear();
        @(negedge clk); gamma_clk = 1'b0; spike_in = '0;
        @(negedge clk); gamma_clk = 1'b1;
        @(negedge clk);
        @(negedge clk); #1;
        chk_out("R8 clear out", '0);
        chk_win("R8 clear win", '0);
    endtask

    task automatic test_reset();
        chk_out("R1 reset out", '0);
        chk_win("R1 reset win", '0);
    endtask

    task automatic test_idle();
        for (int c = 0; c < 5; c++) drive('0);
        chk_out("R9 idle out", '0);
        chk_win("R9 idle win", '0);
        wave_clear();
        chk_win("R9 idle after clear", '0);
    endtask

    task automatic test_single(input int n);
        logic [Q-1:0] e;
        e = Q'(1) << n;
        drive(e);
        chk_out("R2 passthrough", e);
        drive('0);
        chk_out("R5 held", e);
        chk_win("R7 winner", e);
        drive(e | 8'h01);
        chk_out("R6 repeat ignored", e);
        drive(~e);
        chk_out("R6 others ignored", e);
        drive('0);
        chk_win("R6 winner kept", e);
        wave_clear();
    endtask

    task automatic test_tie(input logic [Q-1:0] v);
        logic [Q-1:0] e;
        e = lowest(v);
        drive(v);
        chk_out("R4 tie out", e);
        drive('0);
        chk_win("R4 tie winner", e);
        wave_clear();
    endtask

    task automatic test_stagger();
        drive(8'h80);
        chk_out("R3 first", 8'h80);
        drive(8'h01);
        chk_out("R3 later lower index", 8'h80);
        drive(8'h7F);
        chk_out("R3 later many", 8'h80);
        drive('0);
        chk_win("R3 winner", 8'h80);
        wave_clear();
    endtask

    task automatic test_drop_in_clear();
        drive(8'h10);
        drive('0);
        @(negedge clk); gamma_clk = 1'b0;
        @(negedge clk); gamma_clk = 1'b1;   // edge k samples this
        @(negedge clk); spike_in = 8'h02;   // sampled at edge k+1
        @(negedge clk); spike_in = '0; #1;
        chk_out("R8 spike in clear dropped", '0);
        chk_win("R8 spike in clear win", '0);
    endtask

    task automatic test_gamma_held();
        // gamma_clk is left high by the previous clear
        drive(8'h04);
        chk_out("R10 win while high", 8'h04);
        for (int c = 0; c < 4; c++) drive('0);
        chk_out("R10 no reclear", 8'h04);
        chk_win("R10 winner kept", 8'h04);
        wave_clear();
    endtask

    initial begin
        rst = 1'b1; gamma_clk = 1'b0; spike_in = '0;
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        test_reset();
        test_idle();
        test_single(5);
        test_single(0);
        test_single(Q - 1);
        test_tie(8'h18);
        test_tie(8'hC0);
        test_tie(8'hFF);
        test_tie(8'h06);
        test_stagger();
        test_drop_in_clear();
        test_gamma_held();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule